// File: doc/BRIEF.md
# Ordered Masked-Rule Packet Director

This block makes one forwarding decision for every packet header that arrives on one ingress direction of a port pair. Each header comes in as an already extracted tuple: source and destination IPv4 address, source and destination L4 port, VLAN ID, ethertype and IP protocol number. The tuple is compared against a table of `NUM_RULES` rules. Each rule holds a value and a bit mask for every field. The lowest-numbered enabled rule that matches decides the outcome. The decision is a destination port bitmask together with a drop flag.

A two-bit system mode sets what a plain match means. In bypass mode a match is steered to the host and everything else passes to the peer port. In tap mode everything passes to the peer port and a match is also copied to the host. In filter mode a match is kept for the host and everything else is discarded. A rule can instead carry its own action: drop, redirect, or mirror, where mirror sends to the mode's usual destination and also copies to a chosen port. Rules are loaded through a word-wide write port while traffic keeps flowing. Field words are first collected in a staging area. A single commit word then replaces the chosen rule in one clock edge.

Top module: `pdir_director`

## Requirements
- R1: After reset there is no pending decision, `in_ready` is 1, and every rule is disabled.
- R2: Each accepted tuple (`in_valid` and `in_ready` both 1 at a clock edge) produces exactly one decision, in arrival order, on the cycle after acceptance. While `out_valid` is 1 and `out_ready` is 0, the decision holds steady and `in_ready` is 0.
- R3: A rule matches only when `((packet ^ value) & mask) == 0` holds for every field. A mask bit of 0 makes that bit a don't-care, and all fields must agree.
- R4: When several enabled rules match, the lowest index decides. `out_hit` is 1 and `out_rule` gives that index. On a miss `out_hit` and `out_rule` are 0.
- R5: A tuple that matches no enabled rule, including when the table is empty, takes the mode's non-match outcome.
- R6: Bypass mode (`mode`=0): a match with the plain action (code 0) gives the host bit (`HOST_PORT`, default bit 0). A miss gives the peer bit (`PEER_PORT`, default bit 1).
- R7: Tap mode (`mode`=1): a miss gives the peer bit, and a plain match gives both the host bit and the peer bit.
- R8: Filter mode (`mode`=2 or 3): a plain match gives the host bit. A miss gives an empty bitmask with `out_drop`=1. `out_drop` is 1 exactly when the bitmask is empty.
- R9: A matching rule with action code 1 (drop) gives an empty bitmask and `out_drop`=1 in every mode.
- R10: Action code 2 (redirect) gives only the bit of the rule's port index. An index of `NUM_PORTS` or above gives an empty bitmask and a drop.
- R11: Action code 3 (mirror) gives the mode's non-match bitmask ORed with the bit of the rule's port index.
- R12: `cfg_addr[3:0]` selects a word and the upper bits select a rule. The words are: 0/1 source IP value/mask; 2/3 destination IP value/mask; 4/5 {source port[31:16], destination port[15:0]} value/mask; 6/7 {VLAN[27:16], ethertype[15:0]} value/mask; 8/9 protocol[7:0] value/mask; 15 commit. Words 0 to 9 only load staging. The commit word stores staging plus enable[0], action[2:1] and port index[6:4] into the selected rule. A tuple accepted in the same cycle as the commit still sees the old rule, and later tuples see the new one.
- R13: Committing a rule with enable 0 removes it, so lower-priority rules decide again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | System mode: 0 bypass, 1 tap, 2/3 filter |
| in_valid | input | 1 | Tuple valid |
| in_ready | output | 1 | Tuple accepted when high with in_valid |
| in_sip | input | 32 | Source IP |
| in_dip | input | 32 | Destination IP |
| in_sport | input | 16 | Source L4 port |
| in_dport | input | 16 | Destination L4 port |
| in_vid | input | 12 | VLAN ID |
| in_etype | input | 16 | Ethertype |
| in_proto | input | 8 | IP protocol number |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | $clog2(NUM_RULES)+4 | {rule index, word select} |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Decision consumed when high with out_valid |
| out_dest | output | NUM_PORTS | Destination port bitmask |
| out_drop | output | 1 | Packet dropped (empty bitmask) |
| out_hit | output | 1 | An enabled rule matched |
| out_rule | output | $clog2(NUM_RULES) | Index of the deciding rule |

## Verification
Tuples are sent through the same rule set under all four mode codes. This separates the three mode interpretations from one another and shows that code 3 behaves as filter. Single-field hits, misses inside a partial IP mask, and packets that match one field of a two-field rule but not the other tell masked comparison apart from plain equality and AND from OR. Packets that match several rules, a rule removed while others stay, and a commit that lands in the same cycle as a tuple show the priority order and the commit boundary. A long mixed burst under an irregular `out_ready` stall pattern checks ordering and hold behaviour.

// File: rtl/pdir_pkg.sv
package pdir_pkg;
  parameter int IP_W    = 32;
  parameter int L4_W    = 16;
  parameter int VID_W   = 12;
  parameter int ETY_W   = 16;
  parameter int PROTO_W = 8;
  parameter int PIDX_W  = 3;
  parameter int CFG_DW  = 32;
  parameter int WSEL_W  = 4;

  localparam logic [WSEL_W-1:0] W_SIP      = 4'd0;
  localparam logic [WSEL_W-1:0] W_SIP_M    = 4'd1;
  localparam logic [WSEL_W-1:0] W_DIP      = 4'd2;
  localparam logic [WSEL_W-1:0] W_DIP_M    = 4'd3;
  localparam logic [WSEL_W-1:0] W_L4       = 4'd4;
  localparam logic [WSEL_W-1:0] W_L4_M     = 4'd5;
  localparam logic [WSEL_W-1:0] W_VETY     = 4'd6;
  localparam logic [WSEL_W-1:0] W_VETY_M   = 4'd7;
  localparam logic [WSEL_W-1:0] W_PROTO    = 4'd8;
  localparam logic [WSEL_W-1:0] W_PROTO_M  = 4'd9;
  localparam logic [WSEL_W-1:0] W_COMMIT   = 4'd15;

  typedef enum logic [1:0] {
    ACT_PLAIN  = 2'd0,
    ACT_DROP   = 2'd1,
    ACT_REDIR  = 2'd2,
    ACT_MIRROR = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    MODE_BYPASS  = 2'd0,
    MODE_TAP     = 2'd1,
    MODE_FILTER  = 2'd2,
    MODE_FILTER2 = 2'd3
  } mode_e;

  typedef struct packed {
    logic [IP_W-1:0]    sip;
    logic [IP_W-1:0]    dip;
    logic [L4_W-1:0]    sport;
    logic [L4_W-1:0]    dport;
    logic [VID_W-1:0]   vid;
    logic [ETY_W-1:0]   etype;
    logic [PROTO_W-1:0] proto;
  } tuple_t;

  typedef struct packed {
    logic              en;
    act_e              act;
    logic [PIDX_W-1:0] port;
    tuple_t            val;
    tuple_t            msk;
  } rule_t;
endpackage

// File: rtl/pdir_rule_table.sv
module pdir_rule_table
  import pdir_pkg::*;
#(
  parameter int NUM_RULES = 8,
  parameter int RIDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  parameter int CFG_AW    = RIDX_W + WSEL_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [CFG_DW-1:0]         cfg_wdata,
  output rule_t [NUM_RULES-1:0]     rules
);
  tuple_t                sval_q, sval_d;
  tuple_t                smsk_q, smsk_d;
  rule_t [NUM_RULES-1:0] rules_q, rules_d;
  logic [WSEL_W-1:0]     wsel;
  logic [RIDX_W-1:0]     ridx;

  assign wsel = cfg_addr[WSEL_W-1:0];
  assign ridx = cfg_addr[CFG_AW-1:WSEL_W];

  // next state: staging loads, commit copies staging into one rule
  always_comb begin
    sval_d  = sval_q;
    smsk_d  = smsk_q;
    rules_d = rules_q;
    if (cfg_we) begin
      case (wsel)
        W_SIP:     sval_d.sip = cfg_wdata[IP_W-1:0];
        W_SIP_M:   smsk_d.sip = cfg_wdata[IP_W-1:0];
        W_DIP:     sval_d.dip = cfg_wdata[IP_W-1:0];
        W_DIP_M:   smsk_d.dip = cfg_wdata[IP_W-1:0];
        W_L4: begin
          sval_d.sport = cfg_wdata[16 +: L4_W];
          sval_d.dport = cfg_wdata[0 +: L4_W];
        end
        W_L4_M: begin
          smsk_d.sport = cfg_wdata[16 +: L4_W];
          smsk_d.dport = cfg_wdata[0 +: L4_W];
        end
        W_VETY: begin
          sval_d.vid   = cfg_wdata[16 +: VID_W];
          sval_d.etype = cfg_wdata[0 +: ETY_W];
        end
        W_VETY_M: begin
          smsk_d.vid   = cfg_wdata[16 +: VID_W];
          smsk_d.etype = cfg_wdata[0 +: ETY_W];
        end
        W_PROTO:   sval_d.proto = cfg_wdata[0 +: PROTO_W];
        W_PROTO_M: smsk_d.proto = cfg_wdata[0 +: PROTO_W];
        W_COMMIT: begin
          for (int i = 0; i < NUM_RULES; i++) begin
            if (int'(ridx) == i) begin
              rules_d[i].en   = cfg_wdata[0];
              rules_d[i].act  = act_e'(cfg_wdata[2:1]);
              rules_d[i].port = cfg_wdata[4 +: PIDX_W];
              rules_d[i].val  = sval_q;
              rules_d[i].msk  = smsk_q;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sval_q  <= '0;
      smsk_q  <= '0;
      rules_q <= '0;
    end else if (cfg_we) begin
      sval_q  <= sval_d;
      smsk_q  <= smsk_d;
      rules_q <= rules_d;
    end
  end

  assign rules = rules_q;
endmodule

// File: rtl/pdir_match.sv
module pdir_match
  import pdir_pkg::*;
#(
  parameter int NUM_RULES = 8
) (
  input  tuple_t                pkt,
  input  rule_t [NUM_RULES-1:0] rules,
  output logic [NUM_RULES-1:0]  hit
);
  for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
    assign hit[g] = rules[g].en &&
                    (((pkt ^ rules[g].val) & rules[g].msk) == '0);
  end
endmodule

// File: rtl/pdir_first.sv
module pdir_first #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pdir_director.sv
module pdir_director
  import pdir_pkg::*;
#(
  parameter int NUM_RULES = 8,
  parameter int NUM_PORTS = 4,
  parameter int HOST_PORT = 0,
  parameter int PEER_PORT = 1,
  localparam int RIDX_W   = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  localparam int CFG_AW   = RIDX_W + WSEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_sip,
  input  logic [31:0]          in_dip,
  input  logic [15:0]          in_sport,
  input  logic [15:0]          in_dport,
  input  logic [11:0]          in_vid,
  input  logic [15:0]          in_etype,
  input  logic [7:0]           in_proto,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NUM_PORTS-1:0] out_dest,
  output logic                 out_drop,
  output logic                 out_hit,
  output logic [RIDX_W-1:0]    out_rule
);
  localparam logic [NUM_PORTS-1:0] HOST_BIT = NUM_PORTS'(1) << HOST_PORT;
  localparam logic [NUM_PORTS-1:0] PEER_BIT = NUM_PORTS'(1) << PEER_PORT;

  logic                  rst_s0_q, rst_sync_n;
  rule_t [NUM_RULES-1:0] rules;
  logic [NUM_RULES-1:0]  hit_vec, rule_en;
  logic                  any_hit;
  logic [RIDX_W-1:0]     hit_idx;
  tuple_t                pkt;
  rule_t                 sel;
  logic [NUM_PORTS-1:0]  miss_dest, plain_dest, act_bit, dest_d;
  logic                  accept, valid_d;
  logic                  valid_q, drop_q, hit_q;
  logic [NUM_PORTS-1:0]  dest_q;
  logic [RIDX_W-1:0]     rule_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0_q   <= 1'b1;
      rst_sync_n <= rst_s0_q;
    end
  end

  assign pkt = '{sip: in_sip, dip: in_dip, sport: in_sport, dport: in_dport,
                 vid: in_vid, etype: in_etype, proto: in_proto};

  pdir_rule_table #(.NUM_RULES(NUM_RULES)) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .rules    (rules)
  );

  pdir_match #(.NUM_RULES(NUM_RULES)) u_match (
    .pkt  (pkt),
    .rules(rules),
    .hit  (hit_vec)
  );

  pdir_first #(.N(NUM_RULES), .IW(RIDX_W)) u_first (
    .req(hit_vec),
    .any(any_hit),
    .idx(hit_idx)
  );

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_en
    assign rule_en[g] = rules[g].en;
  end

  assign sel = rules[hit_idx];

  // decision for the tuple on the input this cycle
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      act_bit[p] = (int'(sel.port) == p);
    end
    case (mode_e'(mode))
      MODE_BYPASS: begin
        miss_dest  = PEER_BIT;
        plain_dest = HOST_BIT;
      end
      MODE_TAP: begin
        miss_dest  = PEER_BIT;
        plain_dest = HOST_BIT | PEER_BIT;
      end
      default: begin
        miss_dest  = '0;
        plain_dest = HOST_BIT;
      end
    endcase
    if (!any_hit) begin
      dest_d = miss_dest;
    end else begin
      case (sel.act)
        ACT_PLAIN:  dest_d = plain_dest;
        ACT_DROP:   dest_d = '0;
        ACT_REDIR:  dest_d = act_bit;
        default:    dest_d = miss_dest | act_bit;
      endcase
    end
  end

  assign in_ready = rst_sync_n & (~valid_q | out_ready);
  assign accept   = in_valid & in_ready;
  assign valid_d  = accept | (valid_q & ~out_ready);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      dest_q  <= '0;
      drop_q  <= 1'b0;
      hit_q   <= 1'b0;
      rule_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (accept) begin
        dest_q <= dest_d;
        drop_q <= (dest_d == '0);
        hit_q  <= any_hit;
        rule_q <= hit_idx;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_dest  = dest_q;
  assign out_drop  = drop_q;
  assign out_hit   = hit_q;
  assign out_rule  = rule_q;
endmodule

// File: rtl/pdir_checker.sv
module pdir_checker #(
  parameter int NUM_RULES = 8,
  parameter int NUM_PORTS = 4,
  parameter int PEER_PORT = 1,
  localparam int RIDX_W   = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mode,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [NUM_PORTS-1:0] out_dest,
  input logic                 out_drop,
  input logic                 out_hit,
  input logic [RIDX_W-1:0]    out_rule,
  input logic [NUM_RULES-1:0] rule_en
);
  a_r2_accept_gives_decision: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dest) && $stable(out_drop)
                                && $stable(out_hit) && $stable(out_rule));

  a_r2_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  a_r5_empty_table_misses: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (rule_en == '0) |=> !out_hit && (out_rule == '0));

  a_r7_tap_keeps_peer: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (mode == 2'd1) && (rule_en == '0) |=> out_dest[PEER_PORT]);

  a_r8_filter_drops_miss: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode[1] && (rule_en == '0) |=> out_drop && (out_dest == '0));
endmodule

bind pdir_director pdir_checker #(
  .NUM_RULES(NUM_RULES),
  .NUM_PORTS(NUM_PORTS),
  .PEER_PORT(PEER_PORT)
) u_pdir_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .mode     (mode),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_dest (out_dest),
  .out_drop (out_drop),
  .out_hit  (out_hit),
  .out_rule (out_rule),
  .rule_en  (rule_en)
);

// File: tb/tb_pdir_director.sv
`timescale 1ns/1ps
module tb_pdir_director;
  localparam int NR = 8;
  localparam int NP = 4;
  localparam int HOST = 0;
  localparam int PEER = 1;

  logic        clk, rst_n;
  logic [1:0]  mode;
  logic        in_valid, in_ready;
  logic [31:0] in_sip, in_dip;
  logic [15:0] in_sport, in_dport, in_etype;
  logic [11:0] in_vid;
  logic [7:0]  in_proto;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        out_valid, out_ready;
  logic [3:0]  out_dest;
  logic        out_drop, out_hit;
  logic [2:0]  out_rule;

  pdir_director dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_sip(in_sip), .in_dip(in_dip), .in_sport(in_sport), .in_dport(in_dport),
    .in_vid(in_vid), .in_etype(in_etype), .in_proto(in_proto),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest),
    .out_drop(out_drop), .out_hit(out_hit), .out_rule(out_rule)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model state: tuples packed as {sip,dip,sport,dport,vid,etype,proto}
  logic [131:0] m_val [NR];
  logic [131:0] m_msk [NR];
  bit           m_en  [NR];
  int           m_act [NR];
  int           m_port[NR];
  logic [131:0] s_val, s_msk;

  typedef struct {
    logic [3:0] dest;
    bit         drop;
    bit         hit;
    int         idx;
    string      req;
  } exp_t;

  exp_t  q[$];
  string cur_req;
  int    nchk, nfail;
  bit    stall_on, finished;
  int    cyc;

  function automatic exp_t predict(logic [131:0] p, logic [1:0] md);
    exp_t e;
    logic [3:0] miss, plain, pb;
    int first;
    miss  = (md < 2) ? 4'(1 << PEER) : 4'b0;
    plain = (md == 1) ? 4'((1 << HOST) | (1 << PEER)) : 4'(1 << HOST);
    first = -1;
    for (int i = NR - 1; i >= 0; i--)
      if (m_en[i] && (((p ^ m_val[i]) & m_msk[i]) == 132'b0)) first = i;
    e.req = cur_req;
    if (first < 0) begin
      e.dest = miss; e.hit = 0; e.idx = 0;
    end else begin
      e.hit = 1; e.idx = first;
      pb = (m_port[first] < NP) ? 4'(1 << m_port[first]) : 4'b0;
      case (m_act[first])
        0: e.dest = plain;
        1: e.dest = 4'b0;
        2: e.dest = pb;
        default: e.dest = miss | pb;
      endcase
    end
    e.drop = (e.dest == 4'b0);
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          nchk++; nfail++;
          $display("FAIL R2: decision with none pending, dest=%b expected none", out_dest);
        end else begin
          nchk++;
          if (out_dest !== q[0].dest || out_drop !== q[0].drop ||
              out_hit !== q[0].hit || int'(out_rule) != q[0].idx) begin
            nfail++;
            $display("FAIL %s: dest=%b drop=%b hit=%b rule=%0d expected dest=%b drop=%b hit=%b rule=%0d",
                     q[0].req, out_dest, out_drop, out_hit, out_rule,
                     q[0].dest, q[0].drop, q[0].hit, q[0].idx);
          end
          if (out_ready) void'(q.pop_front());
        end
      end
      if (in_valid && in_ready)
        q.push_back(predict({in_sip, in_dip, in_sport, in_dport, in_vid, in_etype, in_proto}, mode));
      if (cfg_we) begin
        case (cfg_addr[3:0])
          4'd0: s_val[131:100] = cfg_wdata;
          4'd1: s_msk[131:100] = cfg_wdata;
          4'd2: s_val[99:68]   = cfg_wdata;
          4'd3: s_msk[99:68]   = cfg_wdata;
          4'd4: s_val[67:36]   = cfg_wdata;
          4'd5: s_msk[67:36]   = cfg_wdata;
          4'd6: s_val[35:8]    = cfg_wdata[27:0];
          4'd7: s_msk[35:8]    = cfg_wdata[27:0];
          4'd8: s_val[7:0]     = cfg_wdata[7:0];
          4'd9: s_msk[7:0]     = cfg_wdata[7:0];
          4'd15: begin
            m_val[cfg_addr[6:4]]  = s_val;
            m_msk[cfg_addr[6:4]]  = s_msk;
            m_en[cfg_addr[6:4]]   = cfg_wdata[0];
            m_act[cfg_addr[6:4]]  = int'(cfg_wdata[2:1]);
            m_port[cfg_addr[6:4]] = int'(cfg_wdata[6:4]);
          end
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= stall_on ? ((cyc % 3) != 0 && (cyc % 7) != 2) : 1'b1;
  end

  task automatic wr(input int rule, input int word, input logic [31:0] d);
    cfg_we = 1; cfg_addr = {3'(rule), 4'(word)}; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic stage(input logic [31:0] sip, sipm, dip, dipm,
                       input logic [15:0] sp, spm, dp, dpm,
                       input logic [11:0] vid, vidm, input logic [15:0] ety, etym,
                       input logic [7:0] pr, prm);
    wr(0, 0, sip); wr(0, 1, sipm); wr(0, 2, dip); wr(0, 3, dipm);
    wr(0, 4, {sp, dp}); wr(0, 5, {spm, dpm});
    wr(0, 6, {4'b0, vid, ety}); wr(0, 7, {4'b0, vidm, etym});
    wr(0, 8, {24'b0, pr}); wr(0, 9, {24'b0, prm});
  endtask

  function automatic logic [31:0] cword(input bit en, input int act, input int port);
    return {25'b0, 3'(port), 1'b0, 2'(act), en};
  endfunction

  task automatic send(input logic [31:0] sip, dip, input logic [15:0] dp,
                      input logic [11:0] vid, input logic [15:0] ety, input logic [7:0] pr);
    in_valid = 1; in_sip = sip; in_dip = dip; in_sport = 16'd1000; in_dport = dp;
    in_vid = vid; in_etype = ety; in_proto = pr;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic sendv(input logic [15:0] dp, input logic [11:0] vid);
    send(32'hC0A80001, 32'h0, dp, vid, 16'h86DD, 8'd17);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    nchk = 0; nfail = 0; stall_on = 0; finished = 0; cyc = 0;
    s_val = '0; s_msk = '0;
    for (int i = 0; i < NR; i++) begin
      m_val[i] = '0; m_msk[i] = '0; m_en[i] = 0; m_act[i] = 0; m_port[i] = 0;
    end
    rst_n = 0; mode = 0; in_valid = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    in_sip = '0; in_dip = '0; in_sport = '0; in_dport = '0; in_vid = '0;
    in_etype = '0; in_proto = '0; out_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    nchk++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      nfail++;
      $display("FAIL R1: in_ready=%b out_valid=%b expected 1 0", in_ready, out_valid);
    end
    @(posedge clk); #1;

    // R1 / R5: empty table, every mode
    cur_req = "R1 empty table filter";
    mode = 2; sendv(16'd80, 12'd5);
    for (int m = 0; m < 4; m++) begin
      cur_req = "R5 empty table miss"; mode = 2'(m); sendv(16'd0, 12'd0);
    end

    // rule 0: destination port 80, plain action
    stage(0, 0, 0, 0, 0, 0, 16'd80, 16'hFFFF, 0, 0, 0, 0, 0, 0);
    wr(0, 15, cword(1, 0, 0));
    cur_req = "R6 bypass"; mode = 0; sendv(16'd80, 0); sendv(16'd81, 0);
    cur_req = "R7 tap";    mode = 1; sendv(16'd80, 0); sendv(16'd81, 0);
    cur_req = "R8 filter"; mode = 2; sendv(16'd80, 0); sendv(16'd81, 0);
    cur_req = "R8 filter code 3"; mode = 3; sendv(16'd80, 0); sendv(16'd81, 0);

    // R3: partial mask on source IP, and a two-field rule
    stage(32'h0A000000, 32'hFF000000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    wr(1, 15, cword(1, 0, 0));
    stage(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0800, 16'hFFFF, 8'd6, 8'hFF);
    wr(2, 15, cword(1, 2, 3));
    cur_req = "R3 masked ip"; mode = 0;
    send(32'h0A123456, 0, 0, 0, 16'h86DD, 8'd17);
    send(32'h0B000000, 0, 0, 0, 16'h86DD, 8'd17);
    cur_req = "R3 all fields"; send(32'h01010101, 0, 0, 0, 16'h0800, 8'd17);
    cur_req = "R10 redirect";  send(32'h01010101, 0, 0, 0, 16'h0800, 8'd6);

    // rules 3..5: mirror on vid 7, drop then redirect on vid 5
    stage(0, 0, 0, 0, 0, 0, 0, 0, 12'd7, 12'hFFF, 0, 0, 0, 0);
    wr(3, 15, cword(1, 3, 3));
    stage(0, 0, 0, 0, 0, 0, 0, 0, 12'd5, 12'hFFF, 0, 0, 0, 0);
    wr(4, 15, cword(1, 1, 0));
    wr(5, 15, cword(1, 2, 2));
    for (int m = 0; m < 3; m++) begin
      mode = 2'(m);
      cur_req = "R9 drop action"; sendv(16'd0, 12'd5);
      cur_req = "R11 mirror";     sendv(16'd0, 12'd7);
      cur_req = "R4 first match"; sendv(16'd80, 12'd5);
    end

    // R13: removing rule 4 lets rule 5 decide
    wr(4, 15, cword(0, 1, 0));
    cur_req = "R13 removed rule"; mode = 0; sendv(16'd0, 12'd5);

    // R12: commit in the same cycle as a tuple
    stage(0, 0, 0, 0, 0, 0, 0, 0, 12'd9, 12'hFFF, 0, 0, 0, 0);
    cur_req = "R12 same-cycle commit";
    cfg_we = 1; cfg_addr = {3'd6, 4'd15}; cfg_wdata = cword(1, 1, 0);
    in_valid = 1; in_sip = 32'hC0A80001; in_dip = 0; in_sport = 16'd1000;
    in_dport = 0; in_vid = 12'd9; in_etype = 16'h86DD; in_proto = 8'd17;
    @(posedge clk); #1;
    cfg_we = 0; in_valid = 0;
    cur_req = "R12 after commit"; sendv(16'd0, 12'd9);
    cur_req = "R12 ignored word"; wr(0, 12, 32'hFFFFFFFF); wr(0, 15, cword(1, 2, 0));
    sendv(16'd0, 12'd9);

    // R10: out-of-range port index; R2: mixed burst under stalls
    stage(0, 0, 0, 0, 0, 0, 0, 0, 12'd11, 12'hFFF, 0, 0, 0, 0);
    wr(7, 15, cword(1, 2, 6));
    cur_req = "R10 port out of range"; sendv(16'd0, 12'd11);
    stall_on = 1;
    cur_req = "R2 ordered burst under stall";
    for (int i = 0; i < 30; i++) begin
      mode = 2'(i % 4);
      sendv((i % 3 == 0) ? 16'd80 : 16'd0, 12'((i * 2) % 13));
    end
    stall_on = 0;
    repeat (10) @(posedge clk);
    #1;
    nchk++;
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL R2: %0d decisions missing, expected 0", q.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule